// File: doc/BRIEF.md
# Row-Locality Migration Statistics Store

This block lives in the memory controller of a two-tier memory, where a small fast tier caches rows of a large slow tier. It sees every slow-tier access, together with a flag telling whether that access found its row already open in the row buffer. For each recently touched slow-tier row it keeps a small counter of row-buffer misses. When that counter reaches the current threshold, the block asks for the row to be copied into the fast tier. Rows that are used often but mostly hit in the open row stay where they are, because a row-buffer hit costs about the same in both tiers.

The counters sit in a set-associative table that behaves like a cache: the low bits of the row address pick a set, the upper bits are the tag, and each set replaces its least recently used way. All counters are wiped at a fixed period, so only rows with recent reuse can climb to the threshold. In static mode the threshold comes straight from a configuration input. In adaptive mode it moves by one step at the end of each interval, after weighing the cost of the migrations it caused against the latency saved by fast-tier row misses.

Top module: `rbla_stat_store`

## Requirements
- R1: An access with `req_in_dram`=1 leaves the table unchanged and never raises a migration request.
- R2: A slow-tier access to a row already in the table adds one to its counter when `req_rb_miss`=1 and leaves the counter unchanged when `req_rb_miss`=0.
- R3: When the updated count of the accessed row is greater than or equal to `cur_thr`, `mig_valid` rises on the next cycle with `mig_row` equal to that row address.
- R4: The set is the low log2(SETS) bits of the row and the tag is the remaining bits. A row not in the table is placed into a free way or, if the set is full, into the least recently used way. It starts with count 1 on a row-buffer miss and count 0 on a row-buffer hit.
- R5: When a migration request is taken (`mig_valid` and `mig_ready` both high), the row's entry is invalidated, so the next access to that row allocates a fresh entry.
- R6: Counters saturate at 2^CNT_W-1 and do not wrap. `cur_thr` is CNT_W+1 bits wide, so a threshold above the counter range is never reached.
- R7: Every CLEAR_PERIOD cycles, all counters are set to zero while tags and recency order are kept. The wipe takes SETS cycles, during which `req_ready` is low. A similar SETS-cycle sweep after reset empties the table.
- R8: While `mig_valid` is high, `req_ready` is low. `mig_valid` and `mig_row` hold until the request is taken.
- R9: With `adapt_en`=1, at each INTERVAL boundary the threshold moves up one if cost exceeds benefit and down one otherwise, and the result is clamped to the range 1 to `cfg_thr_max`. Cost is MIG_COST times the number of migrations taken in the interval. Benefit is MISS_SAVE times the number of accepted fast-tier accesses that had `req_rb_miss`=1.
- R10: With `adapt_en`=0, `cur_thr` equals `cfg_thr` one cycle later. In reset, `mig_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access report present |
| req_ready | output | 1 | Block can take an access report this cycle |
| req_row | input | ROW_W | Row address of the access |
| req_in_dram | input | 1 | Access was served by the fast tier |
| req_rb_miss | input | 1 | Access missed in the row buffer |
| mig_valid | output | 1 | Migration request pending |
| mig_ready | input | 1 | Consumer takes the migration request |
| mig_row | output | ROW_W | Row to migrate |
| adapt_en | input | 1 | Enable adaptive threshold |
| cfg_thr | input | CNT_W+1 | Static threshold, and initial threshold |
| cfg_thr_max | input | CNT_W+1 | Upper clamp for the adaptive threshold |
| cur_thr | output | CNT_W+1 | Threshold currently in use |

## Verification
The hardest situations to reach are those that depend on table history that is not visible at the ports: an entry evicted by LRU, a counter pinned at saturation, and a periodic wipe landing between two accesses. The bench keeps a recency-ordered model of every set and tells the design's behaviour apart by the migration that does or does not follow. It fills a set past its associativity and re-touches rows so that a wrong victim shows up as an early migration. It pushes a counter past its maximum under an unreachable threshold, then lowers the threshold and makes one hit access. It detects each wipe from the stall on `req_ready` and resets the model's counts at that point. The threshold adaptation is driven by long runs of either self-migrating slow-tier misses or fast-tier misses, and the bench checks each step of `cur_thr` and both clamps.

// File: rtl/rbla_pkg.sv
package rbla_pkg;
  typedef enum logic [1:0] {SWP_IDLE, SWP_INIT, SWP_CLEAR} sweep_e;
endpackage

// File: rtl/rbla_period_timer.sv
module rbla_period_timer #(
  parameter int PERIOD = 1000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = $clog2(PERIOD + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == CW'(PERIOD - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/rbla_set_update.sv
// Lookup and update of one set word: hit detection, victim choice,
// counter update, recency aging and threshold compare.
module rbla_set_update #(
  parameter int TAG_W = 8,
  parameter int CNT_W = 4,
  parameter int WAYS  = 16,
  localparam int AGE_W  = $clog2(WAYS),
  localparam int ENT_W  = 1 + TAG_W + CNT_W + AGE_W,
  localparam int WORD_W = WAYS * ENT_W,
  localparam int THR_W  = CNT_W + 1
) (
  input  logic [WORD_W-1:0] word_in,
  input  logic [TAG_W-1:0]  tag,
  input  logic              rb_miss,
  input  logic [THR_W-1:0]  thr,
  output logic [WORD_W-1:0] word_out,
  output logic              do_mig,
  output logic [AGE_W-1:0]  way_sel
);
  logic             vld [WAYS];
  logic [TAG_W-1:0] tg  [WAYS];
  logic [CNT_W-1:0] ct  [WAYS];
  logic [AGE_W-1:0] ag  [WAYS];

  for (genvar g = 0; g < WAYS; g++) begin : g_unpack
    assign {vld[g], tg[g], ct[g], ag[g]} = word_in[g*ENT_W +: ENT_W];
  end

  logic             hit, free;
  logic [AGE_W-1:0] hit_way, free_way, lru_way, sel_age;
  logic [CNT_W-1:0] old_cnt, new_cnt;

  always_comb begin
    hit = 1'b0; free = 1'b0;
    hit_way = '0; free_way = '0; lru_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (vld[w] && tg[w] == tag) begin hit = 1'b1; hit_way = AGE_W'(w); end
      if (!vld[w]) begin free = 1'b1; free_way = AGE_W'(w); end
      if (ag[w] == AGE_W'(WAYS - 1)) lru_way = AGE_W'(w);
    end
    way_sel = hit ? hit_way : (free ? free_way : lru_way);
    sel_age = ag[way_sel];
    old_cnt = ct[way_sel];
    if (hit) new_cnt = (rb_miss && old_cnt != '1) ? old_cnt + 1'b1 : old_cnt;
    else     new_cnt = CNT_W'(rb_miss);
    do_mig = {1'b0, new_cnt} >= thr;
    word_out = word_in;
    for (int w = 0; w < WAYS; w++) begin
      if (AGE_W'(w) == way_sel)
        word_out[w*ENT_W +: ENT_W] = {1'b1, tag, new_cnt, AGE_W'(0)};
      else if (ag[w] < sel_age)
        word_out[w*ENT_W +: ENT_W] = {vld[w], tg[w], ct[w], ag[w] + 1'b1};
    end
  end
endmodule

// File: rtl/rbla_thresh_adapt.sv
module rbla_thresh_adapt #(
  parameter int THR_W     = 5,
  parameter int ACC_W     = 24,
  parameter int INTERVAL  = 10000,
  parameter int MIG_COST  = 64,
  parameter int MISS_SAVE = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adapt_en,
  input  logic [THR_W-1:0] cfg_thr,
  input  logic [THR_W-1:0] cfg_thr_max,
  input  logic             ev_mig,
  input  logic             ev_save,
  output logic [THR_W-1:0] thr
);
  logic             tick;
  logic [ACC_W-1:0] cost_acc, ben_acc, cost_add, ben_add;
  logic [THR_W:0]   nxt;
  logic [THR_W-1:0] nxt_c;

  rbla_period_timer #(.PERIOD(INTERVAL)) u_int_tmr (.clk(clk), .rst(rst), .tick(tick));

  assign cost_add = ev_mig  ? ACC_W'(MIG_COST)  : '0;
  assign ben_add  = ev_save ? ACC_W'(MISS_SAVE) : '0;

  always_comb begin
    if (cost_acc > ben_acc) nxt = {1'b0, thr} + 1'b1;
    else                    nxt = (thr <= THR_W'(1)) ? (THR_W+1)'(1) : {1'b0, thr} - 1'b1;
    if (nxt > {1'b0, cfg_thr_max}) nxt = {1'b0, cfg_thr_max};
    nxt_c = (nxt == '0) ? THR_W'(1) : nxt[THR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cost_acc <= '0;
      ben_acc  <= '0;
      thr      <= cfg_thr;
    end else begin
      cost_acc <= tick ? cost_add : cost_acc + cost_add;
      ben_acc  <= tick ? ben_add  : ben_acc + ben_add;
      if (!adapt_en) thr <= cfg_thr;
      else if (tick) thr <= nxt_c;
    end
  end
endmodule

// File: rtl/rbla_stat_store.sv
module rbla_stat_store
  import rbla_pkg::*;
#(
  parameter int ROW_W        = 24,
  parameter int SETS         = 128,
  parameter int WAYS         = 16,
  parameter int CNT_W        = 4,
  parameter int CLEAR_PERIOD = 100000,
  parameter int INTERVAL     = 10000,
  parameter int MIG_COST     = 64,
  parameter int MISS_SAVE    = 8,
  parameter int ACC_W        = 24,
  localparam int SET_W  = $clog2(SETS),
  localparam int TAG_W  = ROW_W - SET_W,
  localparam int AGE_W  = $clog2(WAYS),
  localparam int ENT_W  = 1 + TAG_W + CNT_W + AGE_W,
  localparam int WORD_W = WAYS * ENT_W,
  localparam int THR_W  = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [ROW_W-1:0] req_row,
  input  logic             req_in_dram,
  input  logic             req_rb_miss,
  output logic             mig_valid,
  input  logic             mig_ready,
  output logic [ROW_W-1:0] mig_row,
  input  logic             adapt_en,
  input  logic [THR_W-1:0] cfg_thr,
  input  logic [THR_W-1:0] cfg_thr_max,
  output logic [THR_W-1:0] cur_thr
);
  logic [WORD_W-1:0] tbl [SETS];

  sweep_e            sweep;
  logic [SET_W-1:0]  sw_ptr, rd_set;
  logic              clear_pend, clr_tick, sweep_start;
  logic [AGE_W-1:0]  pend_way, upd_way;
  logic [WORD_W-1:0] rd_word, upd_word, swp_word, inv_word, wr_word;
  logic              upd_mig, req_fire, pcm_fire, mig_fire, we;

  assign req_ready   = !mig_valid && sweep == SWP_IDLE && !clear_pend;
  assign req_fire    = req_valid && req_ready;
  assign pcm_fire    = req_fire && !req_in_dram;
  assign mig_fire    = mig_valid && mig_ready;
  assign sweep_start = sweep == SWP_IDLE && clear_pend && !mig_valid;

  rbla_period_timer #(.PERIOD(CLEAR_PERIOD)) u_clr_tmr (.clk(clk), .rst(rst), .tick(clr_tick));

  rbla_thresh_adapt #(
    .THR_W(THR_W), .ACC_W(ACC_W), .INTERVAL(INTERVAL),
    .MIG_COST(MIG_COST), .MISS_SAVE(MISS_SAVE)
  ) u_adapt (
    .clk(clk), .rst(rst), .adapt_en(adapt_en), .cfg_thr(cfg_thr),
    .cfg_thr_max(cfg_thr_max), .ev_mig(mig_fire),
    .ev_save(req_fire && req_in_dram && req_rb_miss), .thr(cur_thr)
  );

  always_comb begin
    if (sweep != SWP_IDLE) rd_set = sw_ptr;
    else if (mig_valid)    rd_set = mig_row[SET_W-1:0];
    else                   rd_set = req_row[SET_W-1:0];
  end
  assign rd_word = tbl[rd_set];

  rbla_set_update #(.TAG_W(TAG_W), .CNT_W(CNT_W), .WAYS(WAYS)) u_upd (
    .word_in(rd_word), .tag(req_row[ROW_W-1:SET_W]), .rb_miss(req_rb_miss),
    .thr(cur_thr), .word_out(upd_word), .do_mig(upd_mig), .way_sel(upd_way)
  );

  always_comb begin
    swp_word = rd_word;
    inv_word = rd_word;
    for (int w = 0; w < WAYS; w++) begin
      if (sweep == SWP_INIT)
        swp_word[w*ENT_W +: ENT_W] = {1'b0, TAG_W'(0), CNT_W'(0), AGE_W'(w)};
      else
        swp_word[w*ENT_W + AGE_W +: CNT_W] = '0;
      if (AGE_W'(w) == pend_way) inv_word[w*ENT_W + ENT_W - 1] = 1'b0;
    end
    if (sweep != SWP_IDLE) wr_word = swp_word;
    else if (mig_valid)    wr_word = inv_word;
    else                   wr_word = upd_word;
  end
  assign we = (sweep != SWP_IDLE) || mig_fire || pcm_fire;

  always_ff @(posedge clk) begin
    if (we) tbl[rd_set] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sweep      <= SWP_INIT;
      sw_ptr     <= '0;
      clear_pend <= 1'b0;
      mig_valid  <= 1'b0;
      mig_row    <= '0;
      pend_way   <= '0;
    end else begin
      clear_pend <= clr_tick || (clear_pend && !sweep_start);
      if (sweep_start) begin
        sweep  <= SWP_CLEAR;
        sw_ptr <= '0;
      end else if (sweep != SWP_IDLE) begin
        sw_ptr <= sw_ptr + 1'b1;
        if (sw_ptr == SET_W'(SETS - 1)) sweep <= SWP_IDLE;
      end
      if (pcm_fire && upd_mig) begin
        mig_valid <= 1'b1;
        mig_row   <= req_row;
        pend_way  <= upd_way;
      end else if (mig_fire) begin
        mig_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rbla_stat_store_chk.sv
module rbla_stat_store_chk #(
  parameter int ROW_W = 24,
  parameter int THR_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic [ROW_W-1:0] req_row,
  input logic             req_in_dram,
  input logic             req_rb_miss,
  input logic             mig_valid,
  input logic             mig_ready,
  input logic [ROW_W-1:0] mig_row,
  input logic             adapt_en,
  input logic [THR_W-1:0] cfg_thr,
  input logic [THR_W-1:0] cfg_thr_max,
  input logic [THR_W-1:0] cur_thr
);
  logic             prev_ok, prev_adapt;
  logic [THR_W-1:0] prev_thr, prev_cfg;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_ok <= 1'b0; prev_adapt <= 1'b0; prev_thr <= '0; prev_cfg <= '0;
    end else begin
      prev_ok <= 1'b1; prev_adapt <= adapt_en; prev_thr <= cur_thr; prev_cfg <= cfg_thr;
    end
  end

  p_stall_pending_r8: assert property (@(posedge clk) disable iff (rst)
    mig_valid |-> !req_ready);
  p_hold_req_r8: assert property (@(posedge clk) disable iff (rst)
    (mig_valid && !mig_ready) |=> (mig_valid && $stable(mig_row)));
  p_dram_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_in_dram) |=> !mig_valid);
  p_thr1_miss_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !req_in_dram && req_rb_miss && cur_thr == THR_W'(1))
    |=> (mig_valid && mig_row == $past(req_row)));
  p_thr_step_r9: assert property (@(posedge clk) disable iff (rst)
    (prev_ok && prev_adapt && cur_thr != prev_thr)
    |-> ((cur_thr == prev_thr + 1'b1 || cur_thr + 1'b1 == prev_thr)
         && cur_thr >= THR_W'(1) && cur_thr <= cfg_thr_max));
  p_thr_static_r10: assert property (@(posedge clk) disable iff (rst)
    (prev_ok && !prev_adapt) |-> cur_thr == prev_cfg);
endmodule

bind rbla_stat_store rbla_stat_store_chk #(.ROW_W(ROW_W), .THR_W(CNT_W + 1)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_row(req_row), .req_in_dram(req_in_dram), .req_rb_miss(req_rb_miss),
  .mig_valid(mig_valid), .mig_ready(mig_ready), .mig_row(mig_row),
  .adapt_en(adapt_en), .cfg_thr(cfg_thr), .cfg_thr_max(cfg_thr_max),
  .cur_thr(cur_thr)
);

// File: tb/tb_rbla_stat_store.sv
module tb_rbla_stat_store;
  localparam int ROW_W = 8, SETS = 4, WAYS = 4, CNT_W = 3, THR_W = 4;
  localparam int CMAX = 7;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_in_dram = 1'b0, req_rb_miss = 1'b0;
  logic [ROW_W-1:0] req_row = '0;
  logic req_ready, mig_valid, mig_ready = 1'b0;
  logic [ROW_W-1:0] mig_row;
  logic adapt_en = 1'b0;
  logic [THR_W-1:0] cfg_thr = 4'd3, cfg_thr_max = 4'd3, cur_thr;

  always #10 clk = ~clk;

  rbla_stat_store #(
    .ROW_W(ROW_W), .SETS(SETS), .WAYS(WAYS), .CNT_W(CNT_W),
    .CLEAR_PERIOD(3000), .INTERVAL(64), .MIG_COST(10), .MISS_SAVE(4), .ACC_W(16)
  ) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_row(req_row), .req_in_dram(req_in_dram), .req_rb_miss(req_rb_miss),
    .mig_valid(mig_valid), .mig_ready(mig_ready), .mig_row(mig_row),
    .adapt_en(adapt_en), .cfg_thr(cfg_thr), .cfg_thr_max(cfg_thr_max),
    .cur_thr(cur_thr)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0, hold = 0, no_sb = 0, clr_seen = 0;
  int m_thr = 3;
  int m_row [SETS][$];
  int m_cnt [SETS][$];
  int exp_q [$];
  string exp_rq [$];
  int cyc = 0;

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // wipe observed at the ports: stall with no pending migration
  always @(negedge clk) begin
    cyc++;
    if (!rst && !req_ready && !mig_valid) clr_seen = 1;
  end

  // monitor: drives mig_ready, pops and compares expected migrations
  always @(negedge clk) begin
    logic nv;
    nv = !hold && (cyc % 3 != 0);
    mig_ready = nv;
    if (!rst && mig_valid && nv && !no_sb) begin
      if (exp_q.size() == 0) begin
        check(0, "R3 unexpected migration", mig_row, 0);
      end else begin
        int e; string r;
        e = exp_q.pop_front(); r = exp_rq.pop_front();
        check(mig_row == e[ROW_W-1:0], r, mig_row, e);
      end
    end
  end

  task automatic model_clear();
    for (int s = 0; s < SETS; s++)
      for (int i = 0; i < m_cnt[s].size(); i++) m_cnt[s][i] = 0;
  endtask

  task automatic model_access(input int row, input bit miss, output bit mig);
    int s, idx, c;
    s = row % SETS; idx = -1;
    for (int i = 0; i < m_row[s].size(); i++) if (m_row[s][i] == row) idx = i;
    if (idx >= 0) begin
      c = m_cnt[s][idx];
      if (miss && c < CMAX) c++;
      m_row[s].delete(idx); m_cnt[s].delete(idx);
    end else begin
      c = miss ? 1 : 0;
      if (m_row[s].size() == WAYS) begin void'(m_row[s].pop_back()); void'(m_cnt[s].pop_back()); end
    end
    m_row[s].push_front(row); m_cnt[s].push_front(c);
    mig = (c >= m_thr);
    if (mig) begin void'(m_row[s].pop_front()); void'(m_cnt[s].pop_front()); end
  endtask

  task automatic drive(input int row, input bit dram, input bit miss, input string rq,
                       input bit wait_pop = 1);
    bit exp;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    if (clr_seen) begin model_clear(); clr_seen = 0; end
    req_valid = 1; req_row = row[ROW_W-1:0]; req_in_dram = dram; req_rb_miss = miss;
    exp = 0;
    if (!dram) model_access(row, miss, exp);
    if (exp) begin exp_q.push_back(row); exp_rq.push_back(rq); end
    @(negedge clk);
    req_valid = 0;
    check(mig_valid == exp, rq, mig_valid, exp);
    if (exp && wait_pop)
      for (int i = 0; i < 50 && exp_q.size() != 0; i++) @(negedge clk);
  endtask

  task automatic raw_drive(input int row, input bit dram);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_row = row[ROW_W-1:0]; req_in_dram = dram; req_rb_miss = 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic sync_sweep();
    clr_seen = 0;
    for (int i = 0; i < 4000 && !clr_seen; i++) @(negedge clk);
    while (!req_ready) @(negedge clk);
  endtask

  task automatic set_thr(input int t);
    cfg_thr = t[THR_W-1:0]; m_thr = t;
    @(negedge clk); @(negedge clk);
    check(cur_thr == cfg_thr, "R10 static threshold", cur_thr, cfg_thr);
  endtask

  initial begin
    #(20 * 150000);
    check(0, "watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    int prev;
    repeat (5) @(negedge clk);
    check(mig_valid == 0, "R10 reset state", mig_valid, 0);
    rst = 0;
    @(negedge clk);
    check(req_ready == 0, "R7 init sweep stall", req_ready, 0);
    set_thr(3);

    // R2 R3 R5
    drive(8'h02, 0, 1, "R2"); drive(8'h02, 0, 1, "R2"); drive(8'h02, 0, 1, "R3 mig at thr");
    drive(8'h02, 0, 1, "R5 realloc after take");
    // R2 hits leave count
    drive(8'h06, 0, 1, "R2"); drive(8'h06, 0, 0, "R2 hit"); drive(8'h06, 0, 0, "R2 hit");
    drive(8'h06, 0, 1, "R2"); drive(8'h06, 0, 1, "R2 mig after hits");
    // R1 fast-tier accesses ignored
    drive(8'h0A, 0, 1, "R1"); drive(8'h0A, 0, 1, "R1");
    for (int i = 0; i < 3; i++) drive(8'h0A, 1, 1, "R1 dram access");
    drive(8'h0A, 0, 0, "R1 hit no mig"); drive(8'h0A, 0, 1, "R1 mig");
    // R4 LRU replacement in set 1
    sync_sweep();
    drive(8'h01, 0, 1, "R4"); drive(8'h05, 0, 1, "R4"); drive(8'h09, 0, 1, "R4");
    drive(8'h0D, 0, 1, "R4"); drive(8'h01, 0, 0, "R4"); drive(8'h15, 0, 1, "R4 evict");
    drive(8'h05, 0, 1, "R4 realloc"); drive(8'h05, 0, 1, "R4");
    drive(8'h01, 0, 1, "R4"); drive(8'h01, 0, 1, "R4 mig kept row");
    drive(8'h05, 0, 1, "R4 mig realloc row");
    drive(8'h09, 0, 1, "R4 evicted row"); drive(8'h09, 0, 1, "R4 evicted row");
    // R4 allocation on hit starts at zero
    drive(8'h03, 0, 0, "R4 alloc hit"); drive(8'h03, 0, 1, "R4"); drive(8'h03, 0, 1, "R4");
    drive(8'h03, 0, 1, "R4 mig");
    // R6 saturation
    sync_sweep();
    set_thr(8);
    for (int i = 0; i < 9; i++) drive(8'h07, 0, 1, "R6 no mig");
    set_thr(7);
    drive(8'h07, 0, 0, "R6 saturated count");
    // R7 periodic wipe
    set_thr(3);
    sync_sweep();
    drive(8'h0B, 0, 1, "R7"); drive(8'h0B, 0, 1, "R7");
    sync_sweep();
    drive(8'h0B, 0, 1, "R7 after wipe"); drive(8'h0B, 0, 1, "R7 after wipe");
    drive(8'h0B, 0, 1, "R7 mig");
    // R8 back-pressure, R3 at threshold 1
    set_thr(1);
    hold = 1;
    drive(8'h0F, 0, 1, "R8 R3 thr1", 0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(!req_ready && mig_valid && mig_row == 8'h0F, "R8 hold", {req_ready, mig_valid}, 1);
    end
    hold = 0;
    for (int i = 0; i < 50 && exp_q.size() != 0; i++) @(negedge clk);
    drive(8'h13, 0, 1, "R3 thr1");
    check(exp_q.size() == 0, "R3 all taken", exp_q.size(), 0);

    // R9 adaptive threshold
    no_sb = 1;
    cfg_thr_max = 4'd3;
    repeat (3) @(negedge clk);
    adapt_en = 1;
    prev = cur_thr;
    for (int i = 0; i < 400; i++) begin
      raw_drive(8'h11, 0);
      if (cur_thr != prev) begin
        check(cur_thr == prev + 1 && cur_thr <= 3, "R9 rise", cur_thr, prev + 1);
        prev = cur_thr;
      end
    end
    check(cur_thr == 3, "R9 clamp max", cur_thr, 3);
    for (int i = 0; i < 400; i++) begin
      raw_drive(8'h05, 1);
      if (cur_thr != prev) begin
        check(cur_thr == prev - 1 && cur_thr >= 1, "R9 fall", cur_thr, prev - 1);
        prev = cur_thr;
      end
    end
    check(cur_thr == 1, "R9 clamp min", cur_thr, 1);
    summary();
    $finish;
  end
endmodule